// File: doc/BRIEF.md
# General Purpose Inactivity Timer

This block watches a system for inactivity. An 8-bit down-counter is loaded with a programmed value. It counts down by one on each tick of a free-running prescaler, which gives either a one-second or a one-millisecond period from a 32768 Hz clock. Any selected activity source restarts the count from the programmed value. The sources are peripheral strobes, each gated by its own mask bit, and, as an option, a level change on a general-purpose input pin.

When the count runs out, the block sets a status flag and raises a single-cycle interrupt request. It then stays in the expired state and ignores all activity. Software restarts it by clearing the enable and then setting it again. Software clears the status flag with a write-one-to-clear strobe, and the flag also clears whenever the timer is disabled. Register decoding sits outside this block; every setting arrives as a plain input.

Top module: `idle_gp_timer`

## Requirements
- R1: While reset is asserted and after it is released, `count` is 0 and `running`, `status`, `irq` are all 0.
- R2: On the first clock edge that samples `enable`=1 after it was 0, `count` takes `reload_val` and `running` becomes 1.
- R3: With `tb_ms`=1, a running timer decrements `count` by one every `MS_DIV` (default 33) clock cycles.
- R4: With `tb_ms`=0, a running timer decrements `count` by one every `SEC_DIV` (default 32768) clock cycles. `tb_ms`=0 is the one-second setting.
- R5: Bit i of `src_act` reloads `count` from `reload_val` on the next edge only when bit i of `src_mask` is 1. An unmasked strobe leaves `count` unchanged.
- R6: With `pin_sel`=1, a rising or a falling edge on `gpio_pin` reloads `count` three clock edges after the pin changes (two synchronizer flops plus the edge flop). With `pin_sel`=0, pin edges have no effect.
- R7: A tick that finds `count` at 1 or 0 while running sets `count` to 0, drops `running`, sets `status` and pulses `irq` high for exactly one cycle.
- R8: After expiry, strobes and pin edges are ignored and `count` stays 0. Only deasserting `enable` and then asserting it again reloads the timer.
- R9: A one-cycle `stat_clr` clears `status`, but a simultaneous expiry wins. `enable`=0 clears `status` and stops the timer on the next edge.
- R10: When an activity event and a prescaler tick fall on the same edge, the reload wins and `count` equals `reload_val`.
- R11: The prescaler is never reset by a load, so the first decrement after a load arrives within one tick period, from 1 to `MS_DIV` cycles in millisecond mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32768 Hz timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Timer enable; 0 to 1 loads, 0 stops and clears status |
| tb_ms | input | 1 | Timebase select: 1 = millisecond, 0 = second |
| reload_val | input | CNT_W | Programmed count |
| src_mask | input | NUM_SRC | Per-source activity enable |
| src_act | input | NUM_SRC | Activity strobes from peripherals |
| pin_sel | input | 1 | Pin edges retrigger when 1 |
| gpio_pin | input | 1 | Asynchronous general-purpose input |
| stat_clr | input | 1 | Write-one-to-clear strobe for status |
| count | output | CNT_W | Current count |
| running | output | 1 | Timer is counting |
| status | output | 1 | Sticky expiry flag |
| irq | output | 1 | One-cycle interrupt request on expiry |

## Verification
The assertions check the following on every cycle:
- a disabled timer never runs or holds status;
- a start always shows the programmed value;
- a running count changes only by a decrement of one or by a reload;
- an expired timer keeps its count;
- the interrupt lasts a single cycle and comes with the status flag.

Some behaviour needs planned stimulus, so only the bench's scenarios show it:
- the exact tick periods of both timebases;
- the early first decrement caused by the free-running prescaler;
- mask gating of individual strobes;
- the three-edge latency of the pin path, on both pin polarities;
- reload winning over a coincident tick.

// File: rtl/gpit_pkg.sv
package gpit_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } gpit_state_e;
endpackage

// File: rtl/gpit_div.sv
// Free-running modulo-DIV counter; strobes tick on its last state.
module gpit_div #(
  parameter int DIV = 33
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q == LAST);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/gpit_pin_sync.sv
// Two-flop synchronizer plus history flop; flags either edge.
module gpit_pin_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic pin_edge
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= pin;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign pin_edge = s2_q ^ s3_q;
endmodule

// File: rtl/gpit_core.sv
module gpit_core
  import gpit_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             act,
  input  logic             tick,
  input  logic             stat_clr,
  output logic [CNT_W-1:0] count,
  output logic             running,
  output logic             status,
  output logic             irq
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  gpit_state_e      st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             stat_q, stat_d;
  logic             irq_q, irq_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    irq_d  = 1'b0;
    stat_d = stat_clr ? 1'b0 : stat_q;
    if (!enable) begin
      st_d   = ST_IDLE;
      cnt_d  = '0;
      stat_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          st_d  = ST_RUN;
          cnt_d = reload_val;
        end
        ST_RUN: begin
          if (act) begin
            cnt_d = reload_val;
          end else if (tick) begin
            if (cnt_q <= ONE) begin
              cnt_d  = '0;
              st_d   = ST_DONE;
              stat_d = 1'b1;
              irq_d  = 1'b1;
            end else begin
              cnt_d = cnt_q - ONE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      stat_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      stat_q <= stat_d;
      irq_q  <= irq_d;
    end
  end

  assign count   = cnt_q;
  assign running = (st_q == ST_RUN);
  assign status  = stat_q;
  assign irq     = irq_q;
endmodule

// File: rtl/idle_gp_timer.sv
module idle_gp_timer #(
  parameter int CNT_W   = 8,
  parameter int NUM_SRC = 6,
  parameter int MS_DIV  = 33,
  parameter int SEC_DIV = 32768
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               tb_ms,
  input  logic [CNT_W-1:0]   reload_val,
  input  logic [NUM_SRC-1:0] src_mask,
  input  logic [NUM_SRC-1:0] src_act,
  input  logic               pin_sel,
  input  logic               gpio_pin,
  input  logic               stat_clr,
  output logic [CNT_W-1:0]   count,
  output logic               running,
  output logic               status,
  output logic               irq
);
  localparam int NUM_TB = 2;
  localparam int DIVS [NUM_TB] = '{SEC_DIV, MS_DIV};

  logic [NUM_TB-1:0] tb_tick;
  logic              tick;
  logic              pin_edge;
  logic              act;

  for (genvar g = 0; g < NUM_TB; g++) begin : g_tb
    gpit_div #(.DIV(DIVS[g])) u_div (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tb_tick[g])
    );
  end

  gpit_pin_sync u_pin (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin     (gpio_pin),
    .pin_edge(pin_edge)
  );

  assign tick = tb_tick[tb_ms];
  assign act  = (|(src_act & src_mask)) | (pin_sel & pin_edge);

  gpit_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .reload_val(reload_val),
    .act       (act),
    .tick      (tick),
    .stat_clr  (stat_clr),
    .count     (count),
    .running   (running),
    .status    (status),
    .irq       (irq)
  );
endmodule

// File: rtl/idle_gp_timer_chk.sv
module idle_gp_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic [CNT_W-1:0] reload_val,
  input logic [CNT_W-1:0] count,
  input logic             running,
  input logic             status,
  input logic             irq
);
  // R9: a disabled timer is stopped with status cleared one edge later
  p_disable_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!running && !status));

  // R2: a start shows the programmed count
  p_start_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> (count == $past(reload_val)));

  // R3: while running the count only steps down by one or reloads
  p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(running) && running && (count != $past(count))) |->
      ((count == $past(count) - CNT_W'(1)) || (count == $past(reload_val))));

  // R7: interrupt is a single-cycle pulse alongside status at count zero
  p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  p_irq_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status && (count == '0) && !running));

  // R8: an expired, still-enabled timer keeps its count
  p_expired_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(enable) && enable && $past(status) && status && !$past(running))
      |-> $stable(count));
endmodule

bind idle_gp_timer idle_gp_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .reload_val(reload_val),
  .count     (count),
  .running   (running),
  .status    (status),
  .irq       (irq)
);

// File: tb/idle_gp_timer_tb.sv
module idle_gp_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W   = 8;
  localparam int NSRC    = 6;
  localparam int MS_DIV  = 33;
  localparam int SEC_DIV = 256;
  localparam int WDOG    = 150000;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             enable, tb_ms, pin_sel, gpio_pin, stat_clr;
  logic [CNT_W-1:0] reload_val;
  logic [NSRC-1:0]  src_mask, src_act;
  logic [CNT_W-1:0] count;
  logic             running, status, irq;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  idle_gp_timer #(.CNT_W(CNT_W), .NUM_SRC(NSRC), .MS_DIV(MS_DIV), .SEC_DIV(SEC_DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tb_ms(tb_ms),
    .reload_val(reload_val), .src_mask(src_mask), .src_act(src_act),
    .pin_sel(pin_sel), .gpio_pin(gpio_pin), .stat_clr(stat_clr),
    .count(count), .running(running), .status(status), .irq(irq));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // waits at negedges until count changes; returns cycles waited
  task automatic wait_dec(output int cyc);
    logic [CNT_W-1:0] old;
    old = count;
    cyc = 0;
    while (count == old && cyc < SEC_DIV + 4) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic restart(input logic ms, input logic [CNT_W-1:0] rv);
    @(negedge clk);
    enable = 1'b0;
    tb_ms = ms;
    reload_val = rv;
    @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(count == 0, "R1 count", count, 0);
    chk({running, status, irq} == 3'b000, "R1 flags", {running, status, irq}, 0);
  endtask

  task automatic t_enable_load();
    restart(1'b1, 8'd20);
    chk(count == 20, "R2 load", count, 20);
    chk(running == 1'b1, "R2 running", running, 1);
  endtask

  task automatic t_ms_period();
    int c;
    restart(1'b1, 8'd20);
    wait_dec(c);
    chk(c >= 1 && c <= MS_DIV, "R11 first decrement window", c, MS_DIV);
    chk(count == 19, "R3 first step", count, 19);
    wait_dec(c);
    chk(c == MS_DIV, "R3 ms period", c, MS_DIV);
    chk(count == 18, "R3 second step", count, 18);
  endtask

  task automatic t_sec_period();
    int c;
    restart(1'b0, 8'd9);
    wait_dec(c);
    wait_dec(c);
    chk(c == SEC_DIV, "R4 second period", c, SEC_DIV);
    chk(count == 7, "R4 value", count, 7);
  endtask

  task automatic t_src_mask();
    int c;
    restart(1'b1, 8'd50);
    src_mask = 6'b000100;
    wait_dec(c);
    src_act = 6'b000100;
    @(negedge clk);
    src_act = '0;
    chk(count == 50, "R5 masked source reloads", count, 50);
    wait_dec(c);
    src_act = 6'b111011;
    @(negedge clk);
    src_act = '0;
    chk(count == 49, "R5 unmasked source ignored", count, 49);
  endtask

  task automatic t_pin();
    int c;
    restart(1'b1, 8'd60);
    pin_sel = 1'b1;
    wait_dec(c);
    gpio_pin = 1'b1;
    repeat (2) @(negedge clk);
    chk(count == 59, "R6 before latency", count, 59);
    @(negedge clk);
    chk(count == 60, "R6 rising edge reloads", count, 60);
    wait_dec(c);
    gpio_pin = 1'b0;
    repeat (3) @(negedge clk);
    chk(count == 60, "R6 falling edge reloads", count, 60);
    pin_sel = 1'b0;
    wait_dec(c);
    gpio_pin = 1'b1;
    repeat (4) @(negedge clk);
    chk(count == 59, "R6 unselected pin ignored", count, 59);
    gpio_pin = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_collision();
    int c;
    restart(1'b1, 8'd70);
    src_mask = 6'b000001;
    wait_dec(c);
    repeat (MS_DIV - 1) @(negedge clk);
    src_act = 6'b000001;
    @(negedge clk);
    src_act = '0;
    chk(count == 70, "R10 reload beats tick", count, 70);
  endtask

  task automatic t_expire();
    int c;
    restart(1'b1, 8'd2);
    c = 0;
    while (count != 0 && c < 4 * MS_DIV) begin
      @(negedge clk);
      c++;
    end
    chk(count == 0, "R7 count zero", count, 0);
    chk({running, status, irq} == 3'b011, "R7 expiry flags", {running, status, irq}, 3);
    @(negedge clk);
    chk(irq == 1'b0, "R7 irq single cycle", irq, 0);
  endtask

  task automatic t_expired_ignore();
    src_mask = '1;
    pin_sel = 1'b1;
    src_act = '1;
    gpio_pin = 1'b1;
    @(negedge clk);
    src_act = '0;
    repeat (MS_DIV + 4) @(negedge clk);
    gpio_pin = 1'b0;
    repeat (5) @(negedge clk);
    chk(count == 0, "R8 activity ignored", count, 0);
    chk({running, status} == 2'b01, "R8 stays expired", {running, status}, 1);
    pin_sel = 1'b0;
    enable = 1'b0;
    @(negedge clk);
    chk(status == 1'b0, "R9 disable clears status", status, 0);
    reload_val = 8'd33;
    enable = 1'b1;
    @(negedge clk);
    chk(count == 33 && running, "R8 re-enable restarts", count, 33);
  endtask

  task automatic t_stat_clr();
    t_expire();
    stat_clr = 1'b1;
    @(negedge clk);
    stat_clr = 1'b0;
    chk(status == 1'b0, "R9 w1c clears status", status, 0);
    chk(running == 1'b0 && count == 0, "R9 still expired", count, 0);
  endtask

  initial begin
    rst_n = 1'b0; enable = 1'b0; tb_ms = 1'b0; pin_sel = 1'b0;
    gpio_pin = 1'b0; stat_clr = 1'b0; reload_val = '0;
    src_mask = '0; src_act = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_enable_load();
    t_ms_period();
    t_sec_period();
    t_src_mask();
    t_pin();
    t_collision();
    t_expire();
    t_expired_ignore();
    t_stat_clr();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=0", WDOG);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule